// File: doc/BRIEF.md
# Sixteen-Channel Charge Sum, Peak Channel and Earliest-Time Reducer

This block takes one 10-bit sample from each of sixteen photomultiplier channels on every 100 MHz clock. It scales each sample by a per-channel gain and removes a per-channel baseline. The corrected charges then go through a pipelined reduction tree that produces four results for each sample set: the total charge, the channel holding the largest charge and that charge, and the earliest arrival time among the channels whose time is marked usable. The latency is fixed, so a downstream trigger stage can line the results up with other detector data by counting clock cycles.

Each valid sample set also pushes its sixteen corrected values, as one wide word, into a small first-in first-out buffer. A readout path drains this buffer at its own pace. Gains and baselines are loaded one channel at a time through a simple write strobe.

Top module: `chsum_max_top`

## Requirements
- R1: After reset, every result output is zero, `res_vld` is low, the buffer is empty and not full, every gain is 128 (unity) and every baseline is 0.
- R2: The corrected charge of channel i is floor(sample × gain / 128) − baseline when that value is positive, and 0 otherwise. Gain is an 8-bit fixed-point value with 7 fraction bits.
- R3: A configuration write with `cfg_sel`=0 loads `cfg_data[7:0]` as the gain of channel `cfg_ch`. With `cfg_sel`=1 it loads `cfg_data[9:0]` as that channel's baseline. A new value applies to samples presented at the following clock edge and later, not to a sample taken at the same edge as the write.
- R4: `res_sum` equals the sum of the sixteen corrected charges.
- R5: `res_max_val` is the largest corrected charge and `res_max_idx` is its channel. When several channels tie, the lowest channel number is reported.
- R6: `res_tmin` is the smallest `t_in` among channels with `t_ok` set, and `res_tmin_ok` is 1. When no channel has `t_ok` set, `res_tmin_ok` is 0 and `res_tmin` is all ones.
- R7: A sample set presented with `smp_vld` before clock edge k sets `res_vld` high for the one cycle after edge k+2, with its results on the outputs. The results hold their value until the next valid set arrives.
- R8: Each valid sample set writes its corrected charges into the buffer, with channel i at bits [i×11 +: 11]. The buffer holds 16 entries. A write that arrives while the buffer is full is dropped. `wf_data` shows the oldest entry, and `wf_rd` removes it.
- R9: `wf_rd` while the buffer is empty has no effect: the buffer stays empty and the next write becomes the entry shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample set valid |
| smp_in | input | 160 | Sixteen 10-bit samples, channel i at [i×10 +: 10] |
| t_in | input | 128 | Sixteen 8-bit arrival times |
| t_ok | input | 16 | Per-channel arrival time usable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects gain, 1 selects baseline |
| cfg_ch | input | 4 | Channel being configured |
| cfg_data | input | 10 | Configuration value |
| res_vld | output | 1 | Results below are new this cycle |
| res_sum | output | 15 | Total corrected charge |
| res_max_idx | output | 4 | Channel with largest charge |
| res_max_val | output | 11 | Largest corrected charge |
| res_tmin | output | 8 | Earliest usable arrival time |
| res_tmin_ok | output | 1 | At least one usable time existed |
| wf_rd | input | 1 | Remove the oldest buffered word |
| wf_data | output | 176 | Oldest buffered corrected word |
| wf_empty | output | 1 | Buffer empty |
| wf_full | output | 1 | Buffer full |

## Verification
On every cycle the assertions check that the result strobe follows the middle pipeline stage by exactly one edge, that the total never falls below the peak charge, that an empty time search reports all ones, and that the buffer's occupancy and flags stay consistent. Only the bench's scenarios can show the arithmetic values: the gain and baseline correction with its clamp, the effect of a configuration write at a given edge, the lowest-index rule on ties, the dropping of writes into a full buffer, and the harmless read of an empty one. The bench shows these by comparing every output against a behavioural model on every cycle.

// File: rtl/chsum_pkg.sv
package chsum_pkg;
  parameter int NCH   = 16;
  parameter int SW    = 10;
  parameter int GW    = 8;
  parameter int GFRAC = 7;
  parameter int TW    = 8;

  localparam int IW   = $clog2(NCH);
  localparam int CW   = SW + GW - GFRAC;
  localparam int SUMW = CW + IW;
  localparam logic [GW-1:0] GAIN_ONE = GW'(1 << GFRAC);

  typedef struct packed {
    logic [SUMW-1:0] sum;
    logic [CW-1:0]   mval;
    logic [IW-1:0]   midx;
    logic [TW-1:0]   tmin;
    logic            tok;
  } node_t;

  // gain scale then baseline removal, clamped at zero
  function automatic logic [CW-1:0] correct(input logic [SW-1:0] s,
                                            input logic [GW-1:0] g,
                                            input logic [SW-1:0] p);
    logic [SW+GW-1:0] prod;
    logic [CW-1:0]    scaled;
    prod   = {{GW{1'b0}}, s} * {{SW{1'b0}}, g};
    scaled = prod[SW+GW-1:GFRAC];
    if (scaled > CW'(p)) return scaled - CW'(p);
    return '0;
  endfunction

  function automatic node_t make_leaf(input logic [CW-1:0] c, input logic [IW-1:0] idx,
                                      input logic [TW-1:0] t, input logic ok);
    node_t n;
    n.sum  = SUMW'(c);
    n.mval = c;
    n.midx = idx;
    n.tmin = ok ? t : '1;
    n.tok  = ok;
    return n;
  endfunction

  // lo always covers the lower channel numbers, so ties keep lo
  function automatic node_t merge(input node_t lo, input node_t hi);
    node_t r;
    r.sum = lo.sum + hi.sum;
    if (hi.mval > lo.mval) begin
      r.mval = hi.mval; r.midx = hi.midx;
    end else begin
      r.mval = lo.mval; r.midx = lo.midx;
    end
    if (lo.tok && (!hi.tok || lo.tmin <= hi.tmin)) begin
      r.tmin = lo.tmin; r.tok = 1'b1;
    end else if (hi.tok) begin
      r.tmin = hi.tmin; r.tok = 1'b1;
    end else begin
      r.tmin = '1; r.tok = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/chsum_front.sv
module chsum_front
  import chsum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [NCH*SW-1:0] smp_in,
  input  logic [NCH*TW-1:0] t_in,
  input  logic [NCH-1:0]    t_ok,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IW-1:0]     cfg_ch,
  input  logic [SW-1:0]     cfg_data,
  output node_t             leaf_q [NCH],
  output logic              vld_q
);
  logic [GW-1:0] gain_r [NCH];
  logic [SW-1:0] ped_r  [NCH];
  logic [CW-1:0] corr_w [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_r[i] <= GAIN_ONE;
        ped_r[i]  <= '0;
      end else if (cfg_we && cfg_ch == IW'(i)) begin
        if (cfg_sel) ped_r[i]  <= cfg_data;
        else         gain_r[i] <= cfg_data[GW-1:0];
      end
    end

    assign corr_w[i] = correct(smp_in[i*SW +: SW], gain_r[i], ped_r[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       leaf_q[i] <= '0;
      else if (smp_vld) leaf_q[i] <= make_leaf(corr_w[i], IW'(i), t_in[i*TW +: TW], t_ok[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= smp_vld;
  end
endmodule

// File: rtl/chsum_reduce.sv
module chsum_reduce
  import chsum_pkg::*;
#(
  parameter int NIN  = 16,
  parameter int NOUT = 4
) (
  input  node_t nin  [NIN],
  output node_t nout [NOUT]
);
  localparam int NLV = $clog2(NIN / NOUT);

  node_t work [NIN];

  // in-place pairwise halving; slot i reads 2i and 2i+1 before overwrite
  always_comb begin
    for (int i = 0; i < NIN; i++) work[i] = nin[i];
    for (int lv = 0; lv < NLV; lv++)
      for (int i = 0; i < NIN / 2; i++)
        if (i < (NIN >> (lv + 1))) work[i] = merge(work[2*i], work[2*i+1]);
    for (int o = 0; o < NOUT; o++) nout[o] = work[o];
  end
endmodule

// File: rtl/chsum_fifo.sv
module chsum_fifo #(
  parameter int W     = 176,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign dout    = mem[rp];

  always_ff @(posedge clk) if (push_ok) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  a_r8_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full && $stable(wp));
  a_r9_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty && $stable(rp));
endmodule

// File: rtl/chsum_max_top.sv
module chsum_max_top
  import chsum_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [NCH*SW-1:0] smp_in,
  input  logic [NCH*TW-1:0] t_in,
  input  logic [NCH-1:0]    t_ok,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IW-1:0]     cfg_ch,
  input  logic [SW-1:0]     cfg_data,
  output logic              res_vld,
  output logic [SUMW-1:0]   res_sum,
  output logic [IW-1:0]     res_max_idx,
  output logic [CW-1:0]     res_max_val,
  output logic [TW-1:0]     res_tmin,
  output logic              res_tmin_ok,
  input  logic              wf_rd,
  output logic [NCH*CW-1:0] wf_data,
  output logic              wf_empty,
  output logic              wf_full
);
  localparam int NMID = (NCH >= 4) ? NCH / 4 : 1;

  node_t leaf_q [NCH];
  node_t mid_w  [NMID];
  node_t mid_q  [NMID];
  node_t root_w [1];
  node_t out_q;
  logic  vld_leaf, vld_mid;
  logic [NCH*CW-1:0] wf_din;

  chsum_front u_front (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .t_in(t_in), .t_ok(t_ok), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_ch(cfg_ch), .cfg_data(cfg_data), .leaf_q(leaf_q), .vld_q(vld_leaf)
  );

  chsum_reduce #(.NIN(NCH), .NOUT(NMID)) u_red_lo (.nin(leaf_q), .nout(mid_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NMID; m++) mid_q[m] <= '0;
      vld_mid <= 1'b0;
    end else begin
      if (vld_leaf) for (int m = 0; m < NMID; m++) mid_q[m] <= mid_w[m];
      vld_mid <= vld_leaf;
    end
  end

  chsum_reduce #(.NIN(NMID), .NOUT(1)) u_red_hi (.nin(mid_q), .nout(root_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      res_vld <= 1'b0;
    end else begin
      if (vld_mid) out_q <= root_w[0];
      res_vld <= vld_mid;
    end
  end

  assign res_sum     = out_q.sum;
  assign res_max_idx = out_q.midx;
  assign res_max_val = out_q.mval;
  assign res_tmin    = out_q.tmin;
  assign res_tmin_ok = out_q.tok;

  for (genvar i = 0; i < NCH; i++) begin : g_wf
    assign wf_din[i*CW +: CW] = leaf_q[i].mval;
  end

  chsum_fifo #(.W(NCH*CW), .DEPTH(FIFO_DEPTH)) u_wf (
    .clk(clk), .rst_n(rst_n), .push(vld_leaf), .din(wf_din), .pop(wf_rd),
    .dout(wf_data), .empty(wf_empty), .full(wf_full)
  );

  a_r7_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    vld_mid |=> res_vld);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_mid |=> !res_vld && $stable(res_sum));
  a_r4_sum_covers_peak: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> res_sum >= SUMW'(res_max_val));
  a_r6_empty_search: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_tmin_ok) |-> (&res_tmin));
endmodule

// File: tb/chsum_max_top_tb_top.sv
module chsum_max_top_tb_top;
  import chsum_pkg::*;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 0, cfg_we = 0, cfg_sel = 0, wf_rd = 0;
  logic [NCH*SW-1:0] smp_in = '0;
  logic [NCH*TW-1:0] t_in = '0;
  logic [NCH-1:0]    t_ok = '0;
  logic [IW-1:0]     cfg_ch = '0;
  logic [SW-1:0]     cfg_data = '0;
  logic res_vld, res_tmin_ok, wf_empty, wf_full;
  logic [SUMW-1:0] res_sum;
  logic [IW-1:0]   res_max_idx;
  logic [CW-1:0]   res_max_val;
  logic [TW-1:0]   res_tmin;
  logic [NCH*CW-1:0] wf_data;

  chsum_max_top #(.FIFO_DEPTH(DEPTH)) dut_i (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;

  typedef struct { int sum; int idx; int val; int tm; int ok; } res_t;
  int   m_gain [NCH];
  int   m_ped  [NCH];
  res_t s0, s1, o;
  bit   v0, v1, ov;
  logic [NCH*CW-1:0] fq [$];
  bit   pp_v;
  logic [NCH*CW-1:0] pp_d;

  function automatic int ref_corr(int s, int g, int p);
    int v = (s * g) / 128 - p;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic calc(output res_t r, output logic [NCH*CW-1:0] vec);
    r.sum = 0; r.idx = 0; r.val = -1; r.tm = 1 << TW; r.ok = 0; vec = '0;
    for (int i = 0; i < NCH; i++) begin
      int c = ref_corr(int'(smp_in[i*SW +: SW]), m_gain[i], m_ped[i]);
      r.sum += c;
      if (c > r.val) begin r.val = c; r.idx = i; end
      vec[i*CW +: CW] = CW'(c);
      if (t_ok[i] && int'(t_in[i*TW +: TW]) < r.tm) begin
        r.tm = int'(t_in[i*TW +: TW]); r.ok = 1;
      end
    end
    if (r.ok == 0) r.tm = (1 << TW) - 1;
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin m_gain[i] = 128; m_ped[i] = 0; end
      s0 = '{0,0,0,0,0}; s1 = s0; o = s0; v0 = 0; v1 = 0; ov = 0;
      fq.delete(); pp_v = 0; pp_d = '0;
    end else begin
      res_t nr; logic [NCH*CW-1:0] nv;
      bit push_ok, pop_ok;
      calc(nr, nv);
      push_ok = pp_v && (fq.size() < DEPTH);
      pop_ok  = wf_rd && (fq.size() > 0);
      if (pop_ok) void'(fq.pop_front());
      if (push_ok) fq.push_back(pp_d);
      pp_v = smp_vld; pp_d = nv;
      if (v1) o = s1;
      ov = v1;
      if (v0) s1 = s0;
      v1 = v0;
      if (smp_vld) s0 = nr;
      v0 = smp_vld;
      if (cfg_we) begin
        if (cfg_sel) m_ped[cfg_ch]  = int'(cfg_data);
        else         m_gain[cfg_ch] = int'(cfg_data[GW-1:0]);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_vec(string tag, logic [NCH*CW-1:0] act, logic [NCH*CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 res_vld", int'(res_vld), int'(ov));
      chk("R2 R4 res_sum", int'(res_sum), o.sum);
      chk("R5 res_max_idx", int'(res_max_idx), o.idx);
      chk("R2 R5 res_max_val", int'(res_max_val), o.val);
      chk("R6 res_tmin", int'(res_tmin), o.tm);
      chk("R6 res_tmin_ok", int'(res_tmin_ok), o.ok);
      chk("R8 R9 wf_empty", int'(wf_empty), int'(fq.size() == 0));
      chk("R8 wf_full", int'(wf_full), int'(fq.size() == DEPTH));
      if (fq.size() > 0) chk_vec("R8 wf_data", wf_data, fq[0]);
    end
  end

  task automatic cfg(bit sel, int ch, int val);
    cfg_we = 1; cfg_sel = sel; cfg_ch = IW'(ch); cfg_data = SW'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rand_sample(bit rd);
    smp_vld = 1; wf_rd = rd;
    for (int i = 0; i < NCH; i++) begin
      smp_in[i*SW +: SW] = SW'($urandom_range(0, 1023));
      t_in[i*TW +: TW]   = TW'($urandom_range(0, 255));
      t_ok[i]            = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    smp_vld = 0; wf_rd = 0;
  endtask

  task automatic one_hot_sample(int ch, int val);
    smp_in = '0; smp_in[ch*SW +: SW] = SW'(val); t_ok = '0; smp_vld = 1;
    @(negedge clk);
    smp_vld = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog expired (R7 pipeline hung) actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_vld", int'(res_vld), 0);
    chk("R1 res_sum", int'(res_sum), 0);
    chk("R1 res_tmin_ok", int'(res_tmin_ok), 0);
    chk("R1 wf_empty", int'(wf_empty), 1);
    chk("R1 wf_full", int'(wf_full), 0);
    // unity gain, random data with occasional reads
    for (int n = 0; n < 12; n++) rand_sample($urandom_range(0, 1) == 1);
    repeat (4) @(negedge clk);
    // R3 per-channel gains and baselines, then random data
    for (int i = 0; i < NCH; i++) begin
      cfg(0, i, 100 + 9 * i);
      cfg(1, i, 20 * i);
    end
    for (int n = 0; n < 14; n++) rand_sample(1);
    repeat (4) @(negedge clk);
    // R3 peak gain: 1023*255/128 = 2038 on channel 5
    cfg(0, 5, 255); cfg(1, 5, 0);
    one_hot_sample(5, 1023);
    chk("R3 max gain value", int'(res_max_val), 2038);
    chk("R5 peak channel", int'(res_max_idx), 5);
    // R2 clamp: baseline above the scaled sample gives zero; R5 tie picks channel 0
    cfg(0, 5, 128); cfg(1, 5, 1023);
    one_hot_sample(5, 500);
    chk("R2 clamp sum", int'(res_sum), 0);
    chk("R5 tie lowest index", int'(res_max_idx), 0);
    // R6 no usable time
    chk("R6 none usable flag", int'(res_tmin_ok), 0);
    chk("R6 none usable value", int'(res_tmin), (1 << TW) - 1);
    // R3 write on the same edge as a sample affects only later samples
    cfg_we = 1; cfg_sel = 0; cfg_ch = 2; cfg_data = 10'd64;
    smp_in = '0; smp_in[2*SW +: SW] = 10'd400; smp_vld = 1;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    smp_vld = 0;
    repeat (2) @(negedge clk);
    chk("R3 write applies next sample", int'(res_max_val), ref_corr(400, 64, 40));
    // R8 overfill without reads
    for (int n = 0; n < 20; n++) rand_sample(0);
    repeat (3) @(negedge clk);
    chk("R8 full after overfill", int'(wf_full), 1);
    // drain, then R9 reads while empty
    wf_rd = 1;
    repeat (DEPTH + 4) @(negedge clk);
    chk("R9 empty after extra reads", int'(wf_empty), 1);
    wf_rd = 0;
    rand_sample(0);
    repeat (3) @(negedge clk);
    chk("R9 single entry present", int'(wf_empty), 0);
    wf_rd = 1;
    @(negedge clk);
    wf_rd = 0;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule